// File: doc/BRIEF.md
# Receive Endpoint to Memory DMA Channel

This channel copies the bytes of received packets out of an endpoint bank and writes them one at a time into memory. Software programs a buffer length, a base address and the largest packet size, then raises the channel enable. The channel pops bytes from the bank and writes them to consecutive addresses. A remaining-byte counter counts down as bytes move. The bank is handed back to the endpoint once every byte in it has been taken.

The channel stops in one of two ways. It stops when the buffer is exhausted. It can also stop early when a packet arrives shorter than the largest packet size, which ends a receive whose length is not known in advance. Each kind of stop has its own sticky interrupt cause. After an early stop the counter keeps its value, so software can work out how many bytes arrived. Busy falls in the same cycle that a cause is set.

Both data paths use valid/ready. On the endpoint side, `ep_bank_rdy` acts as valid for the byte at the current bank position and `ep_pop` acts as ready. The bank must hold `ep_data` and `ep_pkt_len` until a pop or a release. On the memory side, `mem_valid` stays high with address and data held until `mem_ready` is seen. At most one write is held in the channel, and no byte is popped while that write is stalled.

Top module: `ep_dma_chan`

## Requirements
- R1: A rising edge of `chan_en` while idle loads `remaining` with `buf_len` and the write address with `base_addr`; `busy` is high from the next cycle.
- R2: Each pop decrements `remaining` by one; the n-th byte of a run is written to `base_addr + n`, in bank order, with the bank's byte as data.
- R3: Once `mem_valid` is high without `mem_ready`, valid, address and data hold; every popped byte is written exactly once.
- R4: `ep_release` pulses with the pop of the last byte of a packet (byte offset equal to length minus one). A bank left partly read when the buffer ends is not released, and the next run continues from its next byte.
- R5: When `remaining` reaches zero, the channel stops after that byte's write is accepted; `irq_eob` is set only if `eob_irq_en` is high.
- R6: With `eot_en` high, a packet with `ep_pkt_len < max_pkt` stops the channel after its last byte is written; `remaining` keeps its value and `irq_eot` is set if `eot_irq_en` is high.
- R7: With `eot_en` low, a short packet is drained and released but the channel keeps running and `irq_eot` stays low.
- R8: With `eot_en` high, a zero-length packet is released with no memory write, the channel stops and `remaining` is unchanged.
- R9: `irq_eob` and `irq_eot` stay set until their clear strobes `clr_eob`/`clr_eot`; a set in the same cycle wins.
- R10: `busy` falls on the same clock edge that sets the stop cause, and `mem_valid` is never high while `busy` is low.
- R11: A start with `buf_len` of zero performs no transfer, leaves `busy` low and sets `irq_eob` (if enabled) at once.
- R12: Dropping `chan_en` during a run stops popping; the channel goes idle after any held write is accepted and sets no cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | 1 | Channel enable; rising edge starts a run |
| eot_en | input | 1 | Allow a short packet to end the run |
| eob_irq_en | input | 1 | Enable the end-of-buffer cause |
| eot_irq_en | input | 1 | Enable the early-end cause |
| buf_len | input | LEN_W | Buffer length in bytes |
| base_addr | input | ADDR_W | First memory write address |
| max_pkt | input | PKT_W | Largest packet size |
| clr_eob | input | 1 | Clear strobe for `irq_eob` |
| clr_eot | input | 1 | Clear strobe for `irq_eot` |
| ep_bank_rdy | input | 1 | Bank holds a packet (valid) |
| ep_pkt_len | input | PKT_W | Length of the packet in the bank |
| ep_data | input | DATA_W | Byte at the current bank position |
| ep_pop | output | 1 | Take one byte (ready) |
| ep_release | output | 1 | Bank fully read; hand it back |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | ADDR_W | Write address |
| mem_data | output | DATA_W | Write data |
| remaining | output | LEN_W | Bytes left in the buffer |
| busy | output | 1 | Channel running |
| irq_eob | output | 1 | Sticky end-of-buffer cause |
| irq_eot | output | 1 | Sticky early-end cause |

## Verification
A start on the clock edge that samples `chan_en` high shows `busy` and the loaded `remaining` one cycle later. A pop on an edge loads the write register at that edge, and the write is counted on the edge where it meets `mem_ready`. Stop causes and the fall of `busy` appear on the edge that accepts the final write, or on the start edge for an empty buffer. The bench drives inputs and samples outputs on falling edges. It waits for `busy` to fall before it checks counts and causes, and it compares the cause just after the fall with its value one cycle before.

// File: rtl/ep_dma_pkg.sv
package ep_dma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } dma_state_e;

  localparam int unsigned CAUSE_EOB = 0;
  localparam int unsigned CAUSE_EOT = 1;
  localparam int unsigned N_CAUSE   = 2;
endpackage

// File: rtl/ep_dma_wbuf.sv
module ep_dma_wbuf #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              mem_ready,
  output logic              mem_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic              slot_free,
  output logic              wr_done
);
  assign wr_done   = mem_valid && mem_ready;
  assign slot_free = !mem_valid || mem_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_valid <= 1'b0;
      mem_addr  <= '0;
      mem_data  <= '0;
    end else if (load) begin
      mem_valid <= 1'b1;
      mem_addr  <= ld_addr;
      mem_data  <= ld_data;
    end else if (mem_ready) begin
      mem_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ep_dma_irq.sv
module ep_dma_irq #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] en,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag
);
  for (genvar i = 0; i < N; i++) begin : g_cause
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                flag[i] <= 1'b0;
      else if (set[i] && en[i])  flag[i] <= 1'b1;
      else if (clr[i])           flag[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/ep_dma_ctrl.sv
module ep_dma_ctrl
  import ep_dma_pkg::*;
#(
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned PKT_W  = 11,
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_en,
  input  logic              eot_en,
  input  logic [LEN_W-1:0]  buf_len,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [PKT_W-1:0]  max_pkt,
  input  logic              bank_rdy,
  input  logic [PKT_W-1:0]  pkt_len,
  input  logic              slot_free,
  input  logic              wb_full,
  input  logic              wr_done,
  output logic              pop,
  output logic              release_bank,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [LEN_W-1:0]  rem,
  output logic              busy,
  output logic              stop_eob,
  output logic              stop_eot
);
  dma_state_e       st_q;
  logic             chan_q;
  logic [LEN_W-1:0] rem_q;
  logic [ADDR_W-1:0] addr_q;
  logic [PKT_W-1:0] ofs_q;
  logic             pend_eob_q, pend_eot_q;

  logic             start, running, zlp, last_byte, is_short, pop_eot, rem_last, exit_drain;
  logic [PKT_W:0]   ofs_inc;

  always_comb begin
    start      = (st_q == ST_IDLE) && chan_en && !chan_q;
    running    = (st_q == ST_RUN) && chan_en && bank_rdy;
    ofs_inc    = {1'b0, ofs_q} + 1'b1;
    last_byte  = (ofs_inc == {1'b0, pkt_len});
    is_short   = (pkt_len < max_pkt);
    zlp        = running && (pkt_len == '0);
    pop        = running && (pkt_len != '0) && slot_free;
    pop_eot    = pop && last_byte && is_short && eot_en;
    rem_last   = (rem_q == LEN_W'(1));
    release_bank = zlp || (pop && last_byte);
    exit_drain = !wb_full || wr_done;
    stop_eob   = (start && (buf_len == '0)) ||
                 ((st_q == ST_DRAIN) && exit_drain && pend_eob_q);
    stop_eot   = (st_q == ST_DRAIN) && exit_drain && pend_eot_q;
  end

  assign wr_addr = addr_q;
  assign rem     = rem_q;
  assign busy    = (st_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      chan_q     <= 1'b0;
      rem_q      <= '0;
      addr_q     <= '0;
      ofs_q      <= '0;
      pend_eob_q <= 1'b0;
      pend_eot_q <= 1'b0;
    end else begin
      chan_q <= chan_en;
      unique case (st_q)
        ST_IDLE: begin
          if (start) begin
            rem_q  <= buf_len;
            addr_q <= base_addr;
            if (buf_len != '0) st_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (!chan_en) begin
            st_q       <= ST_DRAIN;
            pend_eob_q <= 1'b0;
            pend_eot_q <= 1'b0;
          end else if (zlp && eot_en) begin
            st_q       <= ST_DRAIN;
            pend_eob_q <= 1'b0;
            pend_eot_q <= 1'b1;
          end else if (pop && (rem_last || pop_eot)) begin
            st_q       <= ST_DRAIN;
            pend_eob_q <= rem_last;
            pend_eot_q <= pop_eot;
          end
        end
        ST_DRAIN: begin
          if (exit_drain) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
      if (pop) begin
        rem_q  <= rem_q - 1'b1;
        addr_q <= addr_q + 1'b1;
      end
      if (release_bank)  ofs_q <= '0;
      else if (pop)      ofs_q <= ofs_q + 1'b1;
    end
  end
endmodule

// File: rtl/ep_dma_chan.sv
module ep_dma_chan
  import ep_dma_pkg::*;
#(
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned PKT_W  = 11,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_en,
  input  logic              eot_en,
  input  logic              eob_irq_en,
  input  logic              eot_irq_en,
  input  logic [LEN_W-1:0]  buf_len,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [PKT_W-1:0]  max_pkt,
  input  logic              clr_eob,
  input  logic              clr_eot,
  input  logic              ep_bank_rdy,
  input  logic [PKT_W-1:0]  ep_pkt_len,
  input  logic [DATA_W-1:0] ep_data,
  output logic              ep_pop,
  output logic              ep_release,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic [LEN_W-1:0]  remaining,
  output logic              busy,
  output logic              irq_eob,
  output logic              irq_eot
);
  logic              slot_free, wr_done, stop_eob, stop_eot;
  logic [ADDR_W-1:0] wr_addr;
  logic [N_CAUSE-1:0] c_set, c_en, c_clr, c_flag;

  ep_dma_ctrl #(.LEN_W(LEN_W), .PKT_W(PKT_W), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .eot_en(eot_en),
    .buf_len(buf_len), .base_addr(base_addr), .max_pkt(max_pkt),
    .bank_rdy(ep_bank_rdy), .pkt_len(ep_pkt_len),
    .slot_free(slot_free), .wb_full(mem_valid), .wr_done(wr_done),
    .pop(ep_pop), .release_bank(ep_release), .wr_addr(wr_addr),
    .rem(remaining), .busy(busy), .stop_eob(stop_eob), .stop_eot(stop_eot)
  );

  ep_dma_wbuf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) wbuf_i (
    .clk(clk), .rst_n(rst_n), .load(ep_pop), .ld_addr(wr_addr), .ld_data(ep_data),
    .mem_ready(mem_ready), .mem_valid(mem_valid), .mem_addr(mem_addr),
    .mem_data(mem_data), .slot_free(slot_free), .wr_done(wr_done)
  );

  always_comb begin
    c_set = '0; c_en = '0; c_clr = '0;
    c_set[CAUSE_EOB] = stop_eob;   c_set[CAUSE_EOT] = stop_eot;
    c_en[CAUSE_EOB]  = eob_irq_en; c_en[CAUSE_EOT]  = eot_irq_en;
    c_clr[CAUSE_EOB] = clr_eob;    c_clr[CAUSE_EOT] = clr_eot;
  end

  ep_dma_irq #(.N(N_CAUSE)) irq_i (
    .clk(clk), .rst_n(rst_n), .set(c_set), .en(c_en), .clr(c_clr), .flag(c_flag)
  );

  assign irq_eob = c_flag[CAUSE_EOB];
  assign irq_eot = c_flag[CAUSE_EOT];
endmodule

// File: rtl/ep_dma_chan_chk.sv
module ep_dma_chan_chk #(
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ep_pop,
  input logic              ep_bank_rdy,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_data,
  input logic [LEN_W-1:0]  remaining,
  input logic              busy,
  input logic              irq_eob,
  input logic              irq_eot
);
  a_r3_hold_stalled_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

  a_r2_count_per_pop: assert property (@(posedge clk) disable iff (!rst_n)
    ep_pop |=> (remaining == LEN_W'($past(remaining) - 1'b1)));

  a_r10_no_write_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_valid);

  a_r10_eot_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_eot) |-> !busy);

  a_r10_eob_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_eob) |-> !busy);

  a_r4_pop_needs_bank: assert property (@(posedge clk) disable iff (!rst_n)
    ep_pop |-> ep_bank_rdy);
endmodule

bind ep_dma_chan ep_dma_chan_chk #(.LEN_W(LEN_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .ep_pop(ep_pop), .ep_bank_rdy(ep_bank_rdy),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
  .mem_data(mem_data), .remaining(remaining), .busy(busy),
  .irq_eob(irq_eob), .irq_eot(irq_eot)
);

// File: tb/ep_dma_chan_tb_top.sv
module ep_dma_chan_tb_top;
  localparam int unsigned LEN_W = 16, PKT_W = 11, ADDR_W = 16, DATA_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic chan_en = 0, eot_en = 0, eob_irq_en = 0, eot_irq_en = 0, clr_eob = 0, clr_eot = 0;
  logic [LEN_W-1:0]  buf_len = '0;
  logic [ADDR_W-1:0] base_addr = '0;
  logic [PKT_W-1:0]  max_pkt = PKT_W'(4);
  logic ep_bank_rdy = 0, ep_pop, ep_release, mem_valid, mem_ready = 1, busy, irq_eob, irq_eot;
  logic [PKT_W-1:0]  ep_pkt_len = '0;
  logic [DATA_W-1:0] ep_data, mem_data;
  logic [ADDR_W-1:0] mem_addr;
  logic [LEN_W-1:0]  remaining;

  logic [7:0]  bank [16];
  logic [3:0]  ptr = '0;
  logic [15:0] got_addr [32];
  logic [7:0]  got_data [32];
  int wcnt = 0, rel_cnt = 0, rdy_mode = 0, cyc = 0;
  int n_chk = 0, n_fail = 0;
  logic eob_before, eot_before;

  always #5 clk = ~clk;

  ep_dma_chan #(.LEN_W(LEN_W), .PKT_W(PKT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .eot_en(eot_en),
    .eob_irq_en(eob_irq_en), .eot_irq_en(eot_irq_en), .buf_len(buf_len),
    .base_addr(base_addr), .max_pkt(max_pkt), .clr_eob(clr_eob), .clr_eot(clr_eot),
    .ep_bank_rdy(ep_bank_rdy), .ep_pkt_len(ep_pkt_len), .ep_data(ep_data),
    .ep_pop(ep_pop), .ep_release(ep_release), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
    .remaining(remaining), .busy(busy), .irq_eob(irq_eob), .irq_eot(irq_eot)
  );

  assign ep_data = bank[ptr];

  // endpoint bank and memory models
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (ep_pop) ptr <= ptr + 1'b1;
    if (ep_release) begin ep_bank_rdy <= 1'b0; rel_cnt <= rel_cnt + 1; end
    if (mem_valid && mem_ready) begin
      got_addr[wcnt[4:0]] <= mem_addr;
      got_data[wcnt[4:0]] <= mem_data;
      wcnt <= wcnt + 1;
    end
  end

  always @(negedge clk)
    mem_ready <= (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? ~mem_ready : 1'b0;

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  task automatic clear_log();
    @(negedge clk);
    wcnt = 0; rel_cnt = 0;
  endtask

  task automatic start_ch(input int len, input int base);
    @(negedge clk);
    chan_en = 1'b0;
    @(negedge clk);
    buf_len = LEN_W'(len); base_addr = ADDR_W'(base); chan_en = 1'b1;
  endtask

  task automatic send_pkt(input int len, input int seed);
    int n = 0;
    @(negedge clk);
    while (ep_bank_rdy && n < 2000) begin @(negedge clk); n++; end
    for (int i = 0; i < 16; i++) bank[i] = 8'(seed + i);
    ptr = '0; ep_pkt_len = PKT_W'(len); ep_bank_rdy = 1'b1;
  endtask

  task automatic wait_idle();
    int n = 0;
    @(posedge clk); @(negedge clk);
    eob_before = irq_eob; eot_before = irq_eot;
    while (busy && n < 2000) begin
      eob_before = irq_eob; eot_before = irq_eot;
      @(negedge clk); n++;
    end
    if (n >= 2000) check("R5", "channel did not stop", 1, 0);
  endtask

  task automatic clear_causes();
    @(negedge clk); clr_eob = 1; clr_eot = 1;
    @(negedge clk); clr_eob = 0; clr_eot = 0;
  endtask

  task automatic t_reset();
    check("R1", "busy after reset", busy, 0);
    check("R9", "irq_eob after reset", irq_eob, 0);
    check("R9", "irq_eot after reset", irq_eot, 0);
    check("R3", "mem_valid after reset", mem_valid, 0);
    check("R1", "remaining after reset", remaining, 0);
  endtask

  task automatic t_full_buffer();
    clear_log(); rdy_mode = 1;
    eot_en = 1; eob_irq_en = 1; eot_irq_en = 1; max_pkt = 4;
    start_ch(8, 'h100);
    @(negedge clk);
    check("R1", "busy after start", busy, 1);
    check("R1", "remaining loaded", remaining, 8);
    send_pkt(4, 'h10); send_pkt(4, 'h20);
    wait_idle();
    check("R3", "write count", wcnt, 8);
    for (int i = 0; i < 8; i++) begin
      check("R2", "address", got_addr[i], 'h100 + i);
      check("R2", "data", got_data[i], (i < 4) ? ('h10 + i) : ('h20 + i - 4));
    end
    check("R5", "remaining at end", remaining, 0);
    check("R5", "irq_eob set", irq_eob, 1);
    check("R10", "irq_eob low while busy", eob_before, 0);
    check("R6", "irq_eot for full packets", irq_eot, 0);
    check("R4", "banks released", rel_cnt, 2);
    rdy_mode = 0;
  endtask

  task automatic t_clear();
    clear_causes();
    check("R9", "irq_eob cleared", irq_eob, 0);
  endtask

  task automatic t_short_stop();
    clear_log();
    start_ch(20, 'h200);
    send_pkt(4, 'h30); send_pkt(2, 'h40);
    wait_idle();
    check("R6", "write count", wcnt, 6);
    check("R6", "remaining kept", remaining, 14);
    check("R6", "irq_eot set", irq_eot, 1);
    check("R10", "irq_eot low while busy", eot_before, 0);
    check("R6", "irq_eob", irq_eob, 0);
    check("R6", "last address", got_addr[5], 'h205);
    check("R6", "last data", got_data[5], 'h41);
    clear_causes();
    check("R9", "irq_eot cleared", irq_eot, 0);
  endtask

  task automatic t_short_no_eot();
    clear_log(); eot_en = 0;
    start_ch(6, 'h300);
    send_pkt(2, 'h50);
    send_pkt(4, 'h60);
    wait_idle();
    check("R7", "write count", wcnt, 6);
    check("R7", "remaining", remaining, 0);
    check("R7", "irq_eot stays low", irq_eot, 0);
    check("R7", "irq_eob", irq_eob, 1);
    check("R7", "data after short packet", got_data[2], 'h60);
    clear_causes(); eot_en = 1;
  endtask

  task automatic t_zero_len();
    clear_log();
    start_ch(10, 'h400);
    send_pkt(0, 0);
    wait_idle();
    check("R8", "no write", wcnt, 0);
    check("R8", "remaining unchanged", remaining, 10);
    check("R8", "irq_eot", irq_eot, 1);
    check("R8", "bank released", rel_cnt, 1);
    check("R8", "bank free", ep_bank_rdy, 0);
    clear_causes();
  endtask

  task automatic t_mid_packet();
    clear_log();
    start_ch(3, 'h500);
    send_pkt(4, 'h70);
    wait_idle();
    check("R4", "writes before end", wcnt, 3);
    check("R4", "partial bank kept", ep_bank_rdy, 1);
    check("R4", "no release", rel_cnt, 0);
    clear_causes(); clear_log();
    start_ch(5, 'h600);
    send_pkt(4, 'h80);
    wait_idle();
    check("R4", "continuation address", got_addr[0], 'h600);
    check("R4", "continuation data", got_data[0], 'h73);
    check("R4", "next packet data", got_data[1], 'h80);
    check("R4", "release count", rel_cnt, 2);
    check("R5", "irq_eob", irq_eob, 1);
    clear_causes();
  endtask

  task automatic t_eob_masked();
    clear_log(); eob_irq_en = 0; max_pkt = 2;
    start_ch(2, 'h700);
    send_pkt(2, 'h90);
    wait_idle();
    check("R5", "write count", wcnt, 2);
    check("R5", "masked irq_eob", irq_eob, 0);
    eob_irq_en = 1; max_pkt = 4;
  endtask

  task automatic t_zero_buffer();
    clear_log();
    start_ch(0, 'h800);
    @(negedge clk);
    check("R11", "busy stays low", busy, 0);
    check("R11", "irq_eob at once", irq_eob, 1);
    check("R11", "no write", wcnt, 0);
    clear_causes();
  endtask

  task automatic t_abort();
    clear_log(); rdy_mode = 2;
    start_ch(6, 'h900);
    send_pkt(4, 'hA0);
    repeat (4) @(negedge clk);
    chan_en = 0;
    repeat (3) @(negedge clk);
    check("R12", "busy held by stalled write", busy, 1);
    rdy_mode = 0;
    wait_idle();
    check("R12", "one write", wcnt, 1);
    check("R12", "remaining", remaining, 5);
    check("R12", "no eob", irq_eob, 0);
    check("R12", "no eot", irq_eot, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_buffer();
    t_clear();
    t_short_stop();
    t_short_no_eot();
    t_zero_len();
    t_mid_packet();
    t_eob_masked();
    t_zero_buffer();
    t_abort();
    summary();
  end
endmodule